// File: doc/BRIEF.md
# Split-Table Negative Exponential Unit

This unit turns the scaled squared distance that the classifier's distance datapath produces into a kernel weight of the form e^(-x). The input is a 44-bit fixed-point product. The unit does not evaluate the exponential over the full argument. It keeps a 28-bit window of the product and cuts that window into a 14-bit upper field and a 14-bit lower field. Because e^(-(b+c)) equals e^(-b) times e^(-c), two small tables, each with 16K entries, take the place of one table with 2^28 entries. The table memories sit outside the block. It drives their read addresses and receives 16-bit unsigned fractions back one cycle later.

Two shortcuts skip the tables. A product large enough that the exponential falls below the output precision is detected from its upper bits and gives zero. An upstream flag marking an exactly-zero product gives the largest kernel value. Every path has the same three-cycle latency, so results leave the unit in the order their inputs arrived. The result feeds the per-class accumulation.

Top module: `exp_split_unit`

## Requirements
- R1: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high three clock edges later. `out_valid` is never high otherwise, and results leave in input order whichever path each one takes.
- R2: When `in_zero` is low and any product bit from 43 down to 29 is set, `out_kernel` is 16'h0000.
- R3: When `in_zero` is low, bits 43..29 are clear and bits 28 and 27 are both set, `out_kernel` is 16'h0000. When only one of bits 28 and 27 is set, the table path is used.
- R4: When `in_zero` is high, `out_kernel` is 16'hFFFF whatever the product holds, even if a saturation condition of R2 or R3 is also present.
- R5: One edge after an input is accepted, `hi_addr` equals product bits 28..15 and `lo_addr` equals product bits 14..1.
- R6: On the table path, `out_kernel` is bits 31..16 of the 32-bit unsigned product `hi_data * lo_data`. Both tables are sampled two edges after the input, that is, one cycle after the address they answer.
- R7: During and right after reset, `out_valid` is 0 and `out_kernel` is 16'h0000.
- R8: Product bit 0 has no effect: two products that differ only in bit 0 give the same `out_kernel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input product is present this cycle |
| in_zero | input | 1 | Upstream marks the product as exactly zero |
| in_prod | input | 44 | Fixed-point product from the distance multiplier |
| hi_addr | output | 14 | Read address of the upper-field table |
| lo_addr | output | 14 | Read address of the lower-field table |
| hi_data | input | 16 | Upper-field table entry, one cycle after its address |
| lo_data | input | 16 | Lower-field table entry, one cycle after its address |
| out_valid | output | 1 | Kernel value is present this cycle |
| out_kernel | output | 16 | Kernel value, unsigned fraction, 16'hFFFF for one |

## Verification
The one-shortcut and the saturation shortcut can both apply to the same input. The bench raises `in_zero` together with products that have bit 43 set, and together with products that have bits 28 and 27 both set, and expects 16'hFFFF, so the flag must win. The bench also interleaves saturating, flagged and table-path inputs back to back and in bursts with gaps. Each result is judged against a queue built from the requirements, and each is checked for arriving exactly three cycles after its input.

// File: rtl/exp_split_pkg.sv
package exp_split_pkg;

  // How a given input is resolved
  typedef enum logic [1:0] {
    PATH_TABLE = 2'd0,
    PATH_ZERO  = 2'd1,
    PATH_ONE   = 2'd2
  } kpath_e;

endpackage

// File: rtl/exp_split_front.sv
module exp_split_front
  import exp_split_pkg::*;
#(
  parameter int PROD_W  = 44,
  parameter int ARG_LSB = 1,
  parameter int HI_W    = 14,
  parameter int LO_W    = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_zero,
  input  logic [PROD_W-1:0] in_prod,
  output logic              sat_hit,
  output logic              s1_valid,
  output kpath_e            s1_path,
  output logic [HI_W-1:0]   hi_addr,
  output logic [LO_W-1:0]   lo_addr
);

  localparam int ARG_W   = HI_W + LO_W;
  localparam int ARG_MSB = ARG_LSB + ARG_W - 1;
  localparam int TOP_W   = PROD_W - ARG_MSB + 1;

  // Upper slice: bits above the argument window plus its two top bits
  function automatic logic over_range(input logic [TOP_W-1:0] u);
    return (|u[TOP_W-1:2]) || (&u[1:0]);
  endfunction

  logic [TOP_W-1:0]   top_bits;
  logic [ARG_W-1:0]   arg;
  logic [ARG_LSB-1:0] lsb_unused;

  assign top_bits   = in_prod[PROD_W-1:ARG_MSB-1];
  assign arg        = in_prod[ARG_MSB:ARG_LSB];
  assign lsb_unused = in_prod[ARG_LSB-1:0];
  assign sat_hit    = over_range(top_bits);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_path  <= PATH_TABLE;
      hi_addr  <= '0;
      lo_addr  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_zero)      s1_path <= PATH_ONE;
      else if (sat_hit) s1_path <= PATH_ZERO;
      else              s1_path <= PATH_TABLE;
      if (in_valid) begin
        hi_addr <= arg[ARG_W-1:LO_W];
        lo_addr <= arg[LO_W-1:0];
      end
    end
  end

  AST_ADDR_FIELDS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (hi_addr == $past(in_prod[ARG_MSB:ARG_LSB+LO_W]) &&
                  lo_addr == $past(in_prod[ARG_LSB+LO_W-1:ARG_LSB]))); // R5

endmodule

// File: rtl/exp_split_back.sv
module exp_split_back
  import exp_split_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  kpath_e            s1_path,
  input  logic [FRAC_W-1:0] hi_data,
  input  logic [FRAC_W-1:0] lo_data,
  output logic              out_valid,
  output logic [FRAC_W-1:0] out_kernel
);

  localparam int MUL_W = 2 * FRAC_W;

  // Product of two unsigned fractions, keeping the upper half
  function automatic logic [FRAC_W-1:0] frac_mul(input logic [FRAC_W-1:0] a,
                                                 input logic [FRAC_W-1:0] b);
    logic [MUL_W-1:0] full;
    full = MUL_W'(a) * MUL_W'(b);
    return full[MUL_W-1:FRAC_W];
  endfunction

  logic              s2_valid;
  kpath_e            s2_path;
  logic [FRAC_W-1:0] table_kernel;

  assign table_kernel = frac_mul(hi_data, lo_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid   <= 1'b0;
      s2_path    <= PATH_TABLE;
      out_valid  <= 1'b0;
      out_kernel <= '0;
    end else begin
      s2_valid  <= s1_valid;
      s2_path   <= s1_path;
      out_valid <= s2_valid;
      if (s2_valid) begin
        case (s2_path)
          PATH_ONE:  out_kernel <= '1;
          PATH_ZERO: out_kernel <= '0;
          default:   out_kernel <= table_kernel;
        endcase
      end
    end
  end

  AST_STAGE_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> ##1 out_valid); // R1

endmodule

// File: rtl/exp_split_unit.sv
module exp_split_unit
  import exp_split_pkg::*;
#(
  parameter int PROD_W  = 44,
  parameter int ARG_LSB = 1,
  parameter int HI_W    = 14,
  parameter int LO_W    = 14,
  parameter int FRAC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_zero,
  input  logic [PROD_W-1:0] in_prod,
  output logic [HI_W-1:0]   hi_addr,
  output logic [LO_W-1:0]   lo_addr,
  input  logic [FRAC_W-1:0] hi_data,
  input  logic [FRAC_W-1:0] lo_data,
  output logic              out_valid,
  output logic [FRAC_W-1:0] out_kernel
);

  localparam int ARG_MSB = ARG_LSB + HI_W + LO_W - 1;

  logic   sat_hit;
  logic   s1_valid;
  kpath_e s1_path;

  exp_split_front #(
    .PROD_W(PROD_W), .ARG_LSB(ARG_LSB), .HI_W(HI_W), .LO_W(LO_W)
  ) u_front (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_zero(in_zero),
    .in_prod(in_prod), .sat_hit(sat_hit), .s1_valid(s1_valid),
    .s1_path(s1_path), .hi_addr(hi_addr), .lo_addr(lo_addr)
  );

  exp_split_back #(.FRAC_W(FRAC_W)) u_back (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_path(s1_path),
    .hi_data(hi_data), .lo_data(lo_data),
    .out_valid(out_valid), .out_kernel(out_kernel)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##2 !out_valid); // R1
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_zero && (|in_prod[PROD_W-1:ARG_MSB+1]))
      |=> ##2 (out_kernel == '0)); // R2
  AST_PAIR_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_zero && in_prod[ARG_MSB] && in_prod[ARG_MSB-1])
      |=> ##2 (out_kernel == '0)); // R3
  AST_FLAG_ONE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_zero) |=> ##2 (out_kernel == '1)); // R4
  AST_SAT_FLAG_SEEN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_zero && sat_hit) |=> ##2 (out_kernel == '0)); // R2

endmodule

// File: tb/exp_split_unit_tb.sv
module exp_split_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_zero;
  logic [43:0] in_prod;
  logic [13:0] hi_addr, lo_addr;
  logic [15:0] hi_data, lo_data;
  logic        out_valid;
  logic [15:0] out_kernel;

  always #10 clk = ~clk; // 50 MHz

  exp_split_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_zero(in_zero),
    .in_prod(in_prod), .hi_addr(hi_addr), .lo_addr(lo_addr),
    .hi_data(hi_data), .lo_data(lo_data),
    .out_valid(out_valid), .out_kernel(out_kernel)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int pushed = 0;
  int popped = 0;
  bit finished = 0;

  logic [15:0] exp_k[4096];
  int          exp_c[4096];
  string       exp_t[4096];

  // Behavioural tables: entry = round(65535 * e^-(index * step))
  function automatic logic [15:0] to_frac(input real v);
    int r;
    r = $rtoi(65535.0 * v + 0.5);
    if (r > 65535) r = 65535;
    if (r < 0) r = 0;
    return r[15:0];
  endfunction
  function automatic logic [15:0] tab_hi(input logic [13:0] b);
    return to_frac($exp(-($itor(b) * 16384.0) / 8388608.0));
  endfunction
  function automatic logic [15:0] tab_lo(input logic [13:0] c);
    return to_frac($exp(-$itor(c) / 8388608.0));
  endfunction

  always_ff @(posedge clk) begin
    hi_data <= tab_hi(hi_addr);
    lo_data <= tab_lo(lo_addr);
  end

  always @(posedge clk) cyc <= cyc + 1;

  // Expected kernel from the requirements
  function automatic logic [15:0] model(input logic [43:0] p, input logic z);
    logic [31:0] m;
    if (z) return 16'hFFFF;                          // R4
    if ((|p[43:29]) || (p[28] && p[27])) return 16'h0; // R2, R3
    m = 32'(tab_hi(p[28:15])) * 32'(tab_lo(p[14:1])); // R5, R6
    return m[31:16];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [43:0] p, input logic z, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_zero  = z;
    in_prod  = p;
    exp_k[pushed % 4096] = model(p, z);
    exp_c[pushed % 4096] = cyc + 3;
    exp_t[pushed % 4096] = tag;
    pushed++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_zero  = 1'b0;
      in_prod  = '0;
    end
  endtask

  // Output monitor, sampled between edges
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (popped >= pushed) begin
        check("R1 spurious out_valid", 32'd1, 32'd0);
      end else begin
        check({exp_t[popped % 4096], " kernel"}, 32'(out_kernel), 32'(exp_k[popped % 4096]));
        check("R1 latency", 32'(cyc), 32'(exp_c[popped % 4096]));
        popped++;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog R1 actual=running expected=done");
    summary();
  end

  initial begin
    logic [43:0] p;
    rst = 1'b1; in_valid = 1'b0; in_zero = 1'b0; in_prod = '0;
    repeat (4) @(negedge clk);
    check("R7 reset out_valid", 32'(out_valid), 32'd0);
    check("R7 reset out_kernel", 32'(out_kernel), 32'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R7 after reset out_valid", 32'(out_valid), 32'd0);
    check("R7 after reset out_kernel", 32'(out_kernel), 32'd0);

    // Each single bit: R2 above bit 28, table path below
    for (int i = 0; i < 44; i++) send(44'd1 << i, 1'b0, i > 28 ? "R2 single bit" : "R6 single bit");
    idle(3);
    // Pair rule
    send((44'd1 << 28) | (44'd1 << 27), 1'b0, "R3 both top bits");
    send((44'd1 << 28) | ((44'd1 << 27) - 1), 1'b0, "R3 only bit28");
    send((44'd1 << 28) - 1, 1'b0, "R3 only bit27 and below");
    send(44'h1F_FFFF_FFFF, 1'b0, "R2 many high bits");
    // Flag beats saturation, and zero product
    send(44'd1 << 43, 1'b1, "R4 flag with bit43");
    send((44'd1 << 28) | (44'd1 << 27), 1'b1, "R4 flag with pair");
    send('0, 1'b1, "R4 flag zero product");
    send('0, 1'b0, "R6 zero product no flag");
    idle(2);
    // Bit 0 ignored
    for (int i = 0; i < 40; i++) begin
      p = {15'd0, 29'($urandom)} & ~44'h1800_0000;
      send(p, 1'b0, "R8 bit0 clear");
      send(p | 44'd1, 1'b0, "R8 bit0 set");
    end
    // Lower field sweep and upper field sweep
    for (int c = 0; c < 1024; c++) send({15'd0, 14'd0, 14'(c * 16 + 3), 1'b0}, 1'b0, "R6 low sweep");
    for (int b = 0; b < 12288; b += 24) send({15'd0, 14'(b), 14'h155, 1'b1}, 1'b0, "R5 high sweep");
    // Mixed paths with gaps
    for (int i = 0; i < 400; i++) begin
      p = 44'({$urandom, $urandom}) >> ($urandom % 20);
      send(p, ($urandom % 7) == 0, "R1 mixed order");
      if (($urandom % 5) == 0) idle(1 + $urandom % 3);
    end
    idle(6);
    check("R1 output count", 32'(popped), 32'(pushed));
    summary();
  end

endmodule